// File: doc/BRIEF.md
# Conditional Block State Tracker

This block follows a short predicated run of instructions opened by a 16-bit If-Then instruction. Decode hands it the base condition code and the 4-bit mask from that instruction. From the next cycle on, the block presents the condition code that governs the current instruction and raises a flag while a predicated run is in progress. Each time an instruction inside the run retires, the block steps its 8-bit state. The run ends by itself after the last instruction the mask covers. A run can cover one to four instructions. Each one uses either the base condition or its exact inverse.

The 8-bit state is a base-condition prefix followed by a shifting condition-LSB-and-mask tail. For exception entry, the state is also presented packed into two separate fields of a 32-bit execution status word. A saved word can later be loaded back, and the interrupted run then continues from the slot where it stopped. The block does not evaluate conditions against the flags, decode instructions or model the pipeline.

Top module: `cond_block_tracker`

## Requirements
- R1: After a synchronous active-low reset, `in_block` is 0, `cond_out` is 0 and `save_word` is 0.
- R2: An open request with a nonzero mask loads the state {open_cond, open_mask}. From the next cycle, `cond_out` equals `open_cond` and `in_block` is 1.
- R3: Slot 0 uses the base condition. For slot k (k = 1..3), `cond_out` is the base condition with bit 0 replaced by mask bit (4-k). That bit equals base bit 0 for a "then" slot and its inverse for an "else" slot. Bits [3:1] of `cond_out` stay fixed for the whole run.
- R4: The lowest set bit of the mask sets the run length: mask bit 3 gives 1 instruction, bit 2 gives 2, bit 1 gives 3, bit 0 gives 4. After that many retires, `in_block`, `cond_out` and `save_word` all return to 0.
- R5: A retire while `in_block` is 0 leaves the block idle, with `cond_out` at 0.
- R6: An open request whose mask is 0000 is ignored and opens no run.
- R7: `save_word` carries state bits [1:0] in word bits [26:25] and state bits [7:2] in word bits [15:10]. State bits [7:4] are the current condition and state bits [3:0] are the remaining mask. All other word bits are 0.
- R8: A restore request loads the state from word bits [26:25] and [15:10] and ignores all other bits. The run then continues from the saved slot. If the restored mask part, state bits [3:0], is zero, the block becomes fully idle.
- R9: When requests arrive in the same cycle, restore wins over open, and open wins over retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| open_vld | input | 1 | Opens a run with the decoded condition and mask |
| open_cond | input | 4 | Base condition code of the run |
| open_mask | input | 4 | Then/else pattern and length marker |
| retire | input | 1 | One instruction of the current run retired |
| restore_vld | input | 1 | Load the state from `restore_word` |
| restore_word | input | 32 | Saved execution status word |
| cond_out | output | 4 | Condition code for the current instruction |
| in_block | output | 1 | A predicated run is in progress |
| save_word | output | 32 | Current state packed into the status word fields |

## Verification
The bound checker watches several properties on every cycle:
- A nonzero-mask open enters a run holding the new condition.
- A zero-mask open or a retire while idle leaves the block idle.
- The high condition bits hold steady through a run.
- The block outputs zeros whenever it is idle.
- A restore reproduces the saved field bits.

Only the bench scenarios can show the full ordering of then/else conditions slot by slot, the exact run length for each mask shape, and that a run saved mid-way and overwritten by another run resumes at the right slot after a restore. The same applies to how same-cycle request conflicts resolve to a specific resulting state.

// File: rtl/itb_pkg.sv
// Package: itb_pkg
// Shared widths and the update-source type used by the conditional block
// tracker. Assumes a 4-bit condition code and a 4-bit then/else mask.
package itb_pkg;
    localparam int ITB_COND_W = 4;
    localparam int ITB_MASK_W = 4;
    localparam int ITB_ST_W   = ITB_COND_W + ITB_MASK_W;

    // Which request updates the state register in a cycle
    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_RESTORE = 2'd1,
        UPD_OPEN    = 2'd2,
        UPD_ADVANCE = 2'd3
    } upd_src_e;
endpackage

// File: rtl/itb_open_enc.sv
// Module: itb_open_enc
// Forms the initial run state from the decoded base condition and mask.
// Assumes a mask of all zeros means "no run" (the request is dropped).
module itb_open_enc #(
    parameter int COND_W = 4,
    parameter int MASK_W = 4,
    localparam int ST_W  = COND_W + MASK_W
) (
    input  logic [COND_W-1:0] cond_in,
    input  logic [MASK_W-1:0] mask_in,
    output logic              usable,
    output logic [ST_W-1:0]   state_out
);
    // Purpose: accept only masks that mark at least one slot, pack the state
    always_comb begin
        usable    = |mask_in;
        state_out = {cond_in, mask_in};
    end
endmodule

// File: rtl/itb_field_map.sv
// Module: itb_field_map
// Moves the 8-bit run state to and from two separate fields of a status word.
// The low LO_N state bits sit at LO_LSB and the rest sit at HI_LSB.
// Assumes the two fields do not overlap and fit in the word.
module itb_field_map #(
    parameter int ST_W   = 8,
    parameter int WORD_W = 32,
    parameter int LO_N   = 2,
    parameter int LO_LSB = 25,
    parameter int HI_LSB = 10,
    localparam int HI_N  = ST_W - LO_N
) (
    input  logic [ST_W-1:0]   state_in,
    output logic [WORD_W-1:0] word_out,
    input  logic [WORD_W-1:0] word_in,
    output logic [ST_W-1:0]   state_out
);
    // Purpose: scatter state bits into their word positions, zero elsewhere
    always_comb begin
        word_out = '0;
        for (int i = 0; i < LO_N; i++) word_out[LO_LSB+i] = state_in[i];
        for (int j = 0; j < HI_N; j++) word_out[HI_LSB+j] = state_in[LO_N+j];
    end

    // Purpose: gather state bits from their word positions
    always_comb begin
        state_out = '0;
        for (int i = 0; i < LO_N; i++) state_out[i] = word_in[LO_LSB+i];
        for (int j = 0; j < HI_N; j++) state_out[LO_N+j] = word_in[HI_LSB+j];
    end
endmodule

// File: rtl/itb_state_seq.sv
// Module: itb_state_seq
// Holds the run state and steps it. Priority is restore, then open, then
// retire. Stepping shifts the condition-LSB-and-mask tail left by one and
// clears the whole state when the last slot retires. Assumes the open
// request has already been qualified by the encoder.
module itb_state_seq
    import itb_pkg::*;
#(
    parameter int COND_W = 4,
    parameter int MASK_W = 4,
    localparam int ST_W  = COND_W + MASK_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restore_req,
    input  logic [ST_W-1:0] restore_st,
    input  logic            open_req,
    input  logic [ST_W-1:0] open_st,
    input  logic            retire,
    output logic [ST_W-1:0] state
);
    upd_src_e        src;
    logic [ST_W-1:0] state_nx;
    logic            active;
    logic            last_slot;

    // Purpose: decode activity and whether the current slot is the final one
    always_comb begin
        active    = |state[MASK_W-1:0];
        last_slot = (state[MASK_W-2:0] == '0);
    end

    // Purpose: pick the single request that updates the state this cycle
    always_comb begin
        if (restore_req)          src = UPD_RESTORE;
        else if (open_req)        src = UPD_OPEN;
        else if (retire && active) src = UPD_ADVANCE;
        else                      src = UPD_HOLD;
    end

    // Purpose: compute the next state for the chosen source
    always_comb begin
        unique case (src)
            UPD_RESTORE: state_nx = (|restore_st[MASK_W-1:0]) ? restore_st : '0;
            UPD_OPEN:    state_nx = open_st;
            UPD_ADVANCE: state_nx = last_slot ? '0
                                  : {state[ST_W-1:MASK_W+1], state[MASK_W-1:0], 1'b0};
            default:     state_nx = state;
        endcase
    end

    // Purpose: state register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= '0;
        else        state <= state_nx;
    end
endmodule

// File: rtl/cond_block_tracker.sv
// Module: cond_block_tracker
// Top level of the conditional block tracker. Opens a run from decoded
// condition and mask, steps it per retired instruction, shows the current
// condition, and saves or restores the state through a status word.
// Assumes at most one retire per cycle.
module cond_block_tracker #(
    parameter int COND_W = 4,
    parameter int MASK_W = 4,
    parameter int WORD_W = 32,
    parameter int LO_N   = 2,
    parameter int LO_LSB = 25,
    parameter int HI_LSB = 10,
    localparam int ST_W  = COND_W + MASK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_vld,
    input  logic [COND_W-1:0] open_cond,
    input  logic [MASK_W-1:0] open_mask,
    input  logic              retire,
    input  logic              restore_vld,
    input  logic [WORD_W-1:0] restore_word,
    output logic [COND_W-1:0] cond_out,
    output logic              in_block,
    output logic [WORD_W-1:0] save_word
);
    logic            open_ok;
    logic [ST_W-1:0] open_st;
    logic [ST_W-1:0] rest_st;
    logic [ST_W-1:0] state;

    itb_open_enc #(.COND_W(COND_W), .MASK_W(MASK_W)) u_enc (
        .cond_in   (open_cond),
        .mask_in   (open_mask),
        .usable    (open_ok),
        .state_out (open_st)
    );

    itb_field_map #(
        .ST_W(ST_W), .WORD_W(WORD_W), .LO_N(LO_N),
        .LO_LSB(LO_LSB), .HI_LSB(HI_LSB)
    ) u_map (
        .state_in  (state),
        .word_out  (save_word),
        .word_in   (restore_word),
        .state_out (rest_st)
    );

    itb_state_seq #(.COND_W(COND_W), .MASK_W(MASK_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .restore_req (restore_vld),
        .restore_st  (rest_st),
        .open_req    (open_vld && open_ok),
        .open_st     (open_st),
        .retire      (retire),
        .state       (state)
    );

    // Purpose: present the current condition and run-active flag
    always_comb begin
        cond_out = state[ST_W-1:MASK_W];
        in_block = |state[MASK_W-1:0];
    end
endmodule

// File: rtl/itb_checker.sv
// Module: itb_checker
// Cycle-by-cycle properties of the conditional block tracker, bound to the
// top. Assumes the default field layout parameters are passed through.
module itb_checker #(
    parameter int COND_W = 4,
    parameter int MASK_W = 4,
    parameter int WORD_W = 32,
    parameter int LO_N   = 2,
    parameter int LO_LSB = 25,
    parameter int HI_LSB = 10,
    localparam int ST_W  = COND_W + MASK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              open_vld,
    input logic [COND_W-1:0] open_cond,
    input logic [MASK_W-1:0] open_mask,
    input logic              retire,
    input logic              restore_vld,
    input logic [WORD_W-1:0] restore_word,
    input logic [COND_W-1:0] cond_out,
    input logic              in_block,
    input logic [WORD_W-1:0] save_word
);
    localparam logic [WORD_W-1:0] FIELD_BITS =
        WORD_W'(((64'd1 << LO_N) - 64'd1) << LO_LSB)
      | WORD_W'(((64'd1 << (ST_W - LO_N)) - 64'd1) << HI_LSB);

    logic [ST_W-1:0] word_st;
    // Purpose: state the restore word would load, gathered independently
    always_comb word_st = {restore_word[HI_LSB +: ST_W-LO_N], restore_word[LO_LSB +: LO_N]};

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!in_block && cond_out == '0 && save_word == '0));

    p_open_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_vld && open_vld && open_mask != '0)
        |=> (in_block && cond_out == $past(open_cond)));

    p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_block && !restore_vld && !open_vld)
        |=> (!in_block || cond_out[COND_W-1:1] == $past(cond_out[COND_W-1:1])));

    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_block |-> (cond_out == '0 && save_word == '0));

    p_idle_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_block && !restore_vld && !open_vld) |=> !in_block);

    p_zero_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_block && !restore_vld && open_vld && open_mask == '0) |=> !in_block);

    p_field_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (save_word & ~FIELD_BITS) == '0);

    p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_vld && word_st[MASK_W-1:0] != '0)
        |=> (save_word == ($past(restore_word) & FIELD_BITS)));
endmodule

bind cond_block_tracker itb_checker #(
    .COND_W(COND_W), .MASK_W(MASK_W), .WORD_W(WORD_W),
    .LO_N(LO_N), .LO_LSB(LO_LSB), .HI_LSB(HI_LSB)
) u_itb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .open_vld     (open_vld),
    .open_cond    (open_cond),
    .open_mask    (open_mask),
    .retire       (retire),
    .restore_vld  (restore_vld),
    .restore_word (restore_word),
    .cond_out     (cond_out),
    .in_block     (in_block),
    .save_word    (save_word)
);

// File: tb/cond_block_tracker_test.sv
// Scoreboard bench: driver tasks queue expected outputs per cycle, and a
// monitor pops and compares them on the falling edge.
module cond_block_tracker_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        open_vld = 1'b0;
    logic [3:0]  open_cond = '0;
    logic [3:0]  open_mask = '0;
    logic        retire = 1'b0;
    logic        restore_vld = 1'b0;
    logic [31:0] restore_word = '0;
    logic [3:0]  cond_out;
    logic        in_block;
    logic [31:0] save_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          tag;
        logic [3:0]  c;
        logic        ib;
        logic [31:0] w;
    } exp_t;
    exp_t sbq[$];
    exp_t m_e;

    cond_block_tracker uut (
        .clk(clk), .rst_n(rst_n), .open_vld(open_vld), .open_cond(open_cond),
        .open_mask(open_mask), .retire(retire), .restore_vld(restore_vld),
        .restore_word(restore_word), .cond_out(cond_out), .in_block(in_block),
        .save_word(save_word)
    );

    always #(CLK_P/2) clk = ~clk;

    // Status word layout from R7
    function automatic logic [31:0] pack_word(logic [7:0] st);
        return {5'b0, st[1:0], 9'b0, st[7:2], 10'b0};
    endfunction

    // Mask for a run of n slots; else_pat bit i marks slot i as "else" (R3, R4)
    function automatic logic [3:0] make_mask(logic b0, int n, logic [3:0] else_pat);
        logic [3:0] m = '0;
        for (int i = 1; i < n; i++) m[4-i] = b0 ^ else_pat[i];
        m[4-n] = 1'b1;
        return m;
    endfunction

    // Expected state at slot k of a run
    function automatic logic [7:0] slot_st(logic [3:0] base, logic [3:0] m, int k);
        logic [3:0] rem = 4'(m << k);
        logic lsb = (k == 0) ? base[0] : m[4-k];
        return {base[3:1], lsb, rem};
    endfunction

    task automatic expect_st(int tag, logic [7:0] st);
        exp_t e;
        e.tag = tag; e.c = st[7:4]; e.ib = |st[3:0]; e.w = pack_word(st);
        sbq.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk); #1;
        open_vld = 1'b0; retire = 1'b0; restore_vld = 1'b0;
    endtask

    // Monitor: compare every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            m_e = sbq.pop_front();
            checks++;
            if (cond_out !== m_e.c || in_block !== m_e.ib || save_word !== m_e.w) begin
                errors++;
                $display("FAIL R%0d: cond=%h in_block=%b word=%h, expected cond=%h in_block=%b word=%h",
                         m_e.tag, cond_out, in_block, save_word, m_e.c, m_e.ib, m_e.w);
            end
        end
    end

    // Run a block of n slots; save at slot save_k, overwrite with another run, restore
    task automatic run_block(logic [3:0] base, int n, logic [3:0] else_pat, int save_k);
        logic [3:0]  m = make_mask(base[0], n, else_pat);
        logic [31:0] saved;
        open_cond = base; open_mask = m; open_vld = 1'b1; tick();
        for (int k = 0; k < n; k++) begin
            if (k == save_k) begin
                expect_st(7, slot_st(base, m, k));                 // R7 packing mid-run
                saved = save_word;
                open_cond = 4'h3; open_mask = 4'b1000; open_vld = 1'b1; tick();
                expect_st(2, {4'h3, 4'b1000});                     // R2 new run opened
                restore_word = saved | 32'hF9FF_03FF; restore_vld = 1'b1; tick();
                expect_st(8, slot_st(base, m, k));                 // R8 resumed at slot
            end else begin
                expect_st(3, slot_st(base, m, k));                 // R3 slot condition
            end
            retire = 1'b1; tick();
        end
        expect_st(4, 8'h00);                                       // R4 run ended
        tick();
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        expect_st(1, 8'h00);                                       // R1 reset state
        tick();

        retire = 1'b1; tick();
        expect_st(5, 8'h00);                                       // R5 idle retire
        tick();

        open_cond = 4'hA; open_mask = 4'b0000; open_vld = 1'b1; tick();
        expect_st(6, 8'h00);                                       // R6 zero mask ignored
        tick();

        run_block(4'h0, 1, 4'b0000, 9);
        run_block(4'h1, 2, 4'b0010, 9);
        run_block(4'hA, 3, 4'b0100, 9);
        run_block(4'hC, 4, 4'b1010, 9);
        run_block(4'h5, 4, 4'b0000, 2);
        run_block(4'h8, 3, 4'b0110, 1);
        run_block(4'hB, 4, 4'b1110, 0);

        retire = 1'b1; tick();
        expect_st(5, 8'h00);                                       // R5 retire after run
        tick();

        restore_word = 32'h0000_F000; restore_vld = 1'b1; tick();
        expect_st(8, 8'h00);                                       // R8 zero mask restore idles
        tick();

        open_cond = 4'h6; open_mask = 4'b1000; open_vld = 1'b1; tick();
        expect_st(2, {4'h6, 4'b1000});                             // R2
        restore_word = pack_word({4'h9, 4'b0100}); restore_vld = 1'b1;
        open_cond = 4'h2; open_mask = 4'b1000; open_vld = 1'b1; retire = 1'b1; tick();
        expect_st(9, {4'h9, 4'b0100});                             // R9 restore wins
        open_cond = 4'h7; open_mask = 4'b1000; open_vld = 1'b1; retire = 1'b1; tick();
        expect_st(9, {4'h7, 4'b1000});                             // R9 open beats retire
        retire = 1'b1; tick();
        expect_st(4, 8'h00);                                       // R4 one-slot run ends
        tick();
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule